// File: doc/BRIEF.md
# Protected Scratchpad Write Engine

This block sits between a byte-oriented serial bus receiver and the storage array of a small serial EEPROM. It handles the two scratchpad commands. The write command loads a target address, then fills an 8-byte volatile staging buffer. The read command lets the bus host check the staged data before a separate copy step commits it. The engine receives whole bytes over a valid/ready handshake and returns bytes over a second valid/ready handshake. A single-cycle `txn_end` pulse marks a bus reset and closes the current transaction.

Each data byte that arrives is combined with the byte already stored at the same array location, according to the protection code of its page. The combined byte goes into the staging buffer. The engine fetches both the protection code and the stored byte through a synchronous read port with one cycle of latency.

The engine also keeps a transfer status byte. This byte records the ending offset, a "data not valid" flag and a "data already copied" flag. A CRC-16 lets the host confirm both the write stream and the read-back stream.

Top module: `sp_write_engine`

## Requirements
- R1: After reset the engine waits for a command with `in_ready`=1 and `out_valid`=0. The target address is 0000h and the status byte is 20h (offset 0, invalid flag set, copied flag clear). Every staging byte reads FFh.
- R2: Command byte 0Fh starts a write. The next two bytes are the address, low byte first. Data lands at staging offset T = address bits 2..0. The ending offset E is set to T and advances by one for each further byte. At most 8−T data bytes are accepted, and `in_ready` drops once the byte for offset 7 has been taken.
- R3: For an address below 80h, the page is address/32 and its protection code is read from array address 80h+page. Code 55h stores the array byte and ignores the incoming byte. Code AAh stores the bitwise AND of the incoming byte and the array byte. Any other code stores the incoming byte.
- R4: For an address from 80h to 87h, a byte at offset 0..3 whose current array value is 55h or AAh is not changed: its array value is staged. All other bytes in this range are staged as sent.
- R5: The status byte is {copied, 0, invalid, 0, 0, E[2:0]} from bit 7 down to bit 0. When a write transaction ends, the invalid flag is cleared only if at least one data byte arrived and E is 7. Otherwise it is set.
- R6: Every write command clears the copied flag. A pulse on `aa_set` sets it.
- R7: The CRC-16 uses polynomial x^16+x^15+x^2+1. It is processed least significant bit first, with reflected constant A001h, and starts from 0000h. It covers the command, both address bytes and the data bytes exactly as received. When E reaches 7, the inverted CRC is sent on the output, low byte first.
- R8: Command AAh starts a read. The output is: address low, address high, status, staging bytes T through E, then the inverted CRC-16 (low byte first) of AAh and all the bytes just sent. After that the output is FFh until `txn_end`.
- R9: `txn_end` returns the engine to command wait from any state. An unrecognised command byte, and every byte after it, is accepted and dropped without changing the address, status or staging buffer.
- R10: The address registers change only when both address bytes have arrived. A write that ends after the first address byte leaves the address, E and the staging buffer unchanged.
- R11: An address at 88h or above (including any with a non-zero high byte) is unprotected: data is staged as sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte is available |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Engine takes the byte this cycle |
| txn_end | input | 1 | Bus reset pulse, closes the transaction |
| aa_set | input | 1 | Copy step finished; sets the copied flag |
| out_valid | output | 1 | Byte to transmit is available |
| out_data | output | 8 | Byte to transmit |
| out_ready | input | 1 | Transmitter takes the byte this cycle |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | MEM_AW | Array read address |
| mem_rd_data | input | 8 | Array read data, valid one cycle after the strobe |

## Verification
Writes are sent to four kinds of page: an open page, a page locked by code 55h, a page in AND mode (AAh), and the register row whose protection bytes guard themselves. Comparing these shows whether the merge selects the right source, and whether the protection code is taken per page or per byte. Full rows starting at offset 0 and at offset 5 are compared with a truncated row starting at offset 2. These separate the ending-offset count, the point where input stops, and the invalid-flag decision. An address with a non-zero high byte, an unknown command, and a write cut off after one address byte each probe a path that must leave the staged state untouched or unprotected. The CRC on both the write and read streams confirms which bytes are included.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int          SP_BYTES   = 8;
    localparam int          OFF_W      = $clog2(SP_BYTES);
    localparam logic [7:0]  CMD_WRITE  = 8'h0F;
    localparam logic [7:0]  CMD_READ   = 8'hAA;
    localparam logic [7:0]  CODE_LOCK  = 8'h55;
    localparam logic [7:0]  CODE_AND   = 8'hAA;
    localparam logic [15:0] CRC_POLY_R = 16'hA001;

    typedef enum logic [4:0] {
        S_CMD, S_TA1, S_TA2, S_PROT_RD, S_PROT_WAIT, S_DATA, S_MERGE,
        S_WCRC_LO, S_WCRC_HI,
        S_RTA1, S_RTA2, S_RES, S_RDATA, S_RCRC_LO, S_RCRC_HI,
        S_ONES, S_DROP
    } eng_state_t;

    typedef struct packed {
        logic             copied;
        logic             rsv6;
        logic             invalid;
        logic [1:0]       rsv43;
        logic [OFF_W-1:0] e;
    } status_t;

    function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] prot_merge(logic [7:0] code, logic [7:0] din,
                                              logic [7:0] stored);
        if (code == CODE_LOCK)     return stored;
        else if (code == CODE_AND) return din & stored;
        else                       return din;
    endfunction

endpackage

// File: rtl/sp_crc16.sv
module sp_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import sp_pkg::*;

    logic [15:0] base;
    assign base = clr ? 16'h0000 : crc;

    always_ff @(posedge clk) begin
        if (rst)      crc <= 16'h0000;
        else if (upd) crc <= crc16_step(base, din);
        else          crc <= base;
    end
endmodule

// File: rtl/sp_store.sv
module sp_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)                         cells[g] <= '1;
            else if (we && waddr == AW'(g))  cells[g] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sp_merge.sv
module sp_merge #(
    parameter int PAGES = 4
) (
    input  logic                    in_pages,
    input  logic                    in_regrow,
    input  logic [sp_pkg::OFF_W-1:0] off,
    input  logic [7:0]              page_code,
    input  logic [7:0]              stored,
    input  logic [7:0]              din,
    output logic [7:0]              dout
);
    import sp_pkg::*;

    logic [7:0] code;
    logic       self_guard;

    // protection bytes in the register row guard themselves when set
    assign self_guard = in_regrow && (32'(off) < PAGES) &&
                        (stored == CODE_LOCK || stored == CODE_AND);

    always_comb begin
        if (in_pages)        code = page_code;
        else if (self_guard) code = CODE_LOCK;
        else                 code = 8'h00;
        dout = prot_merge(code, din, stored);
    end
endmodule

// File: rtl/sp_write_engine.sv
module sp_write_engine #(
    parameter int MEM_AW     = 8,
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    input  logic              txn_end,
    input  logic              aa_set,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);
    import sp_pkg::*;

    localparam int PROT_BASE = PAGES * PAGE_BYTES;
    localparam int REG_END   = PROT_BASE + SP_BYTES;
    localparam int PG_SH     = $clog2(PAGE_BYTES);

    eng_state_t       st;
    logic [15:0]      ta;
    logic [7:0]       ta1_tmp;
    logic [OFF_W-1:0] e, cur_off, rd_idx;
    logic             pf, aa, wr_cmd, wr_any;
    logic [7:0]       din_q, prot_q;
    logic [15:0]      crc;
    status_t          status;
    logic             in_fire, out_fire;
    logic             crc_clr, crc_upd;
    logic [7:0]       crc_din, merged, sp_rdata;
    logic             in_pages, in_regrow;
    logic [MEM_AW-1:0] prot_addr, data_addr;
    logic             sp_we;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    assign in_ready  = (st == S_CMD) || (st == S_TA1) || (st == S_TA2) ||
                       (st == S_DATA) || (st == S_ONES) || (st == S_DROP);
    assign out_valid = (st == S_WCRC_LO) || (st == S_WCRC_HI) || (st == S_RTA1) ||
                       (st == S_RTA2) || (st == S_RES) || (st == S_RDATA) ||
                       (st == S_RCRC_LO) || (st == S_RCRC_HI) || (st == S_ONES);

    assign status = '{copied: aa, rsv6: 1'b0, invalid: pf, rsv43: 2'b00, e: e};

    always_comb begin
        case (st)
            S_WCRC_LO, S_RCRC_LO: out_data = ~crc[7:0];
            S_WCRC_HI, S_RCRC_HI: out_data = ~crc[15:8];
            S_RTA1:               out_data = ta[7:0];
            S_RTA2:               out_data = ta[15:8];
            S_RES:                out_data = status;
            S_RDATA:              out_data = sp_rdata;
            default:              out_data = 8'hFF;
        endcase
    end

    // address classification and array addressing
    assign in_pages  = 32'(ta) < PROT_BASE;
    assign in_regrow = !in_pages && (32'(ta) < REG_END);
    assign prot_addr = MEM_AW'(PROT_BASE) + MEM_AW'(ta >> PG_SH);
    assign data_addr = {ta[MEM_AW-1:OFF_W], cur_off};

    assign mem_rd_en   = (st == S_PROT_RD) || (st == S_DATA && in_fire);
    assign mem_rd_addr = (st == S_PROT_RD) ? prot_addr : data_addr;

    // CRC feed: received bytes on write, transmitted bytes on read
    assign crc_clr = in_fire && (st == S_CMD);
    assign crc_upd = (in_fire && ((st == S_CMD) || (st == S_TA1) ||
                                  (st == S_TA2) || (st == S_DATA))) ||
                     (out_fire && ((st == S_RTA1) || (st == S_RTA2) ||
                                   (st == S_RES) || (st == S_RDATA)));
    assign crc_din = in_fire ? in_data : out_data;

    sp_crc16 u_crc (
        .clk (clk), .rst (rst), .clr (crc_clr), .upd (crc_upd),
        .din (crc_din), .crc (crc)
    );

    sp_merge #(.PAGES(PAGES)) u_merge (
        .in_pages  (in_pages),
        .in_regrow (in_regrow),
        .off       (cur_off),
        .page_code (prot_q),
        .stored    (mem_rd_data),
        .din       (din_q),
        .dout      (merged)
    );

    assign sp_we = (st == S_MERGE) && !txn_end;

    sp_store #(.DEPTH(SP_BYTES), .W(8)) u_store (
        .clk (clk), .rst (rst), .we (sp_we), .waddr (cur_off),
        .wdata (merged), .raddr (rd_idx), .rdata (sp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_CMD; ta <= '0; ta1_tmp <= '0; e <= '0; cur_off <= '0;
            rd_idx <= '0; pf <= 1'b1; aa <= 1'b0; wr_cmd <= 1'b0;
            wr_any <= 1'b0; din_q <= '0; prot_q <= '0;
        end else begin
            if (aa_set) aa <= 1'b1;
            if (txn_end) begin
                st     <= S_CMD;
                wr_cmd <= 1'b0;
                wr_any <= 1'b0;
                if (wr_cmd) pf <= !(wr_any && e == '1);
            end else begin
                case (st)
                    S_CMD: if (in_fire) begin
                        if (in_data == CMD_WRITE) begin
                            st <= S_TA1; wr_cmd <= 1'b1; aa <= 1'b0; pf <= 1'b1;
                        end else if (in_data == CMD_READ) begin
                            st <= S_RTA1;
                        end else begin
                            st <= S_DROP;
                        end
                    end
                    S_TA1: if (in_fire) begin
                        ta1_tmp <= in_data; st <= S_TA2;
                    end
                    S_TA2: if (in_fire) begin
                        ta      <= {in_data, ta1_tmp};
                        e       <= ta1_tmp[OFF_W-1:0];
                        cur_off <= ta1_tmp[OFF_W-1:0];
                        wr_any  <= 1'b0;
                        st      <= S_PROT_RD;
                    end
                    S_PROT_RD:   st <= S_PROT_WAIT;
                    S_PROT_WAIT: begin prot_q <= mem_rd_data; st <= S_DATA; end
                    S_DATA: if (in_fire) begin
                        din_q <= in_data; st <= S_MERGE;
                    end
                    S_MERGE: begin
                        e      <= cur_off;
                        wr_any <= 1'b1;
                        if (cur_off == '1) begin
                            pf <= 1'b0; st <= S_WCRC_LO;
                        end else begin
                            cur_off <= cur_off + 1'b1; st <= S_DATA;
                        end
                    end
                    S_WCRC_LO: if (out_fire) st <= S_WCRC_HI;
                    S_WCRC_HI: if (out_fire) st <= S_ONES;
                    S_RTA1:    if (out_fire) st <= S_RTA2;
                    S_RTA2:    if (out_fire) st <= S_RES;
                    S_RES: if (out_fire) begin
                        rd_idx <= ta[OFF_W-1:0]; st <= S_RDATA;
                    end
                    S_RDATA: if (out_fire) begin
                        if (rd_idx == e) st <= S_RCRC_LO;
                        else             rd_idx <= rd_idx + 1'b1;
                    end
                    S_RCRC_LO: if (out_fire) st <= S_RCRC_HI;
                    S_RCRC_HI: if (out_fire) st <= S_ONES;
                    default: ;
                endcase
            end
        end
    end

    // R2: the ending offset never falls below the starting offset
    p_e_not_below_t_r2: assert property (@(posedge clk) disable iff (rst)
        e >= ta[OFF_W-1:0]);

    // R5: storing offset 7 validates the row and offers the CRC
    p_full_row_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (st == S_MERGE && cur_off == '1 && !txn_end) |=> (!pf && out_valid));

    // R6: a write command leaves the copied flag clear
    p_write_clears_aa_r6: assert property (@(posedge clk) disable iff (rst)
        (in_fire && st == S_CMD && in_data == CMD_WRITE && !txn_end) |=> !aa);

    // R8: after the read CRC the line returns all ones
    p_tail_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (out_fire && st == S_RCRC_HI && !txn_end) |=> (out_valid && out_data == 8'hFF));

    // R9: bus reset always brings back command wait
    p_end_to_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        txn_end |=> (in_ready && !out_valid));

    // R10: address registers move only on the second address byte
    p_ta_commit_r10: assert property (@(posedge clk) disable iff (rst)
        !(in_fire && st == S_TA2) |=> $stable(ta));

endmodule

// File: tb/sp_write_engine_tb.sv
`timescale 1ns/1ps
module sp_write_engine_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid = 1'b0;
    logic [7:0] in_data  = 8'h00;
    logic       in_ready;
    logic       txn_end  = 1'b0;
    logic       aa_set   = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       mem_rd_en;
    logic [7:0] mem_rd_addr;
    logic [7:0] mem_rd_data;

    always #4 clk = ~clk;

    sp_write_engine u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
        .in_ready (in_ready), .txn_end (txn_end), .aa_set (aa_set),
        .out_valid (out_valid), .out_data (out_data), .out_ready (out_ready),
        .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data)
    );

    logic [7:0] mem [0:255];
    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int nchk = 0, nfail = 0;
    logic [7:0] exp_q [$];
    logic [7:0] wdat [8];

    // reference model state
    logic [15:0] m_ta = 16'h0000;
    logic [2:0]  m_e  = 3'd0;
    logic        m_pf = 1'b1, m_aa = 1'b0;
    logic [7:0]  m_sp [8];

    function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_stage(logic [15:0] a, logic [2:0] off, logic [7:0] d);
        logic [7:0] code, st;
        st = mem[{a[7:3], off}];
        if (a < 16'h0080) begin
            code = mem[8'h80 + 8'(a >> 5)];
            if (code == 8'h55)      return st;
            else if (code == 8'hAA) return d & st;
            else                    return d;
        end else if (a < 16'h0088) begin
            if (off < 3'd4 && (st == 8'h55 || st == 8'hAA)) return st;
            return d;
        end
        return d;
    endfunction

    task automatic chk(input logic [15:0] got, input logic [15:0] expv, input string tag);
        nchk++;
        if (got !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, expv);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b);
        @(negedge clk); out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        b = out_data;
        @(negedge clk); out_ready = 1'b0;
    endtask

    // monitor: pops the expected stream and compares it with the output
    task automatic expect_out(input string tag);
        logic [7:0] got, expv;
        while (exp_q.size() > 0) begin
            recv(got);
            expv = exp_q.pop_front();
            chk({8'h00, got}, {8'h00, expv}, tag);
        end
    endtask

    task automatic pulse_end();
        @(negedge clk); txn_end = 1'b1;
        @(negedge clk); txn_end = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input string tag);
        logic [15:0] c;
        logic [2:0]  off;
        pulse_end();
        c = ref_crc(16'h0000, 8'h0F); send(8'h0F); m_aa = 1'b0;
        c = ref_crc(c, a[7:0]);  send(a[7:0]);
        c = ref_crc(c, a[15:8]); send(a[15:8]);
        m_ta = a; m_e = a[2:0];
        for (int i = 0; i < n; i++) begin
            off = a[2:0] + 3'(i);
            send(wdat[i]);
            c = ref_crc(c, wdat[i]);
            m_sp[off] = ref_stage(a, off, wdat[i]);
            m_e = off;
        end
        if (n > 0 && m_e == 3'd7) begin
            chk({15'd0, in_ready}, 16'd0, {tag, " R2 input closed after offset 7"});
            exp_q.push_back(~c[7:0]);
            exp_q.push_back(~c[15:8]);
            expect_out({tag, " R7 write crc"});
        end
        pulse_end();
        m_pf = !(n > 0 && m_e == 3'd7);
    endtask

    task automatic do_read(input string tag);
        logic [15:0] c;
        logic [7:0]  es;
        pulse_end();
        send(8'hAA);
        c  = ref_crc(16'h0000, 8'hAA);
        es = {m_aa, 1'b0, m_pf, 2'b00, m_e};
        exp_q.push_back(m_ta[7:0]);  c = ref_crc(c, m_ta[7:0]);
        exp_q.push_back(m_ta[15:8]); c = ref_crc(c, m_ta[15:8]);
        exp_q.push_back(es);         c = ref_crc(c, es);
        for (int i = int'(m_ta[2:0]); i <= int'(m_e); i++) begin
            exp_q.push_back(m_sp[i]); c = ref_crc(c, m_sp[i]);
        end
        exp_q.push_back(~c[7:0]);
        exp_q.push_back(~c[15:8]);
        exp_q.push_back(8'hFF);
        exp_q.push_back(8'hFF);
        expect_out({tag, " R8 read stream"});
        pulse_end();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 8'(i * 7 + 3) : 8'h00;
        mem[8'h80] = 8'h00;  // page 0 open, self byte open
        mem[8'h81] = 8'h55;  // page 1 locked
        mem[8'h82] = 8'hAA;  // page 2 AND mode
        mem[8'h83] = 8'h12;  // page 3 open
        for (int i = 0; i < 8; i++) m_sp[i] = 8'hFF;

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk({15'd0, in_ready}, 16'd1, "R1 in_ready after reset");
        chk({15'd0, out_valid}, 16'd0, "R1 out_valid after reset");
        do_read("R1 reset status");

        // open page, full row from offset 0
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h30 + i * 5);
        do_write(16'h0008, 8, "R2 open full row");
        do_read("R2 R5 open full row");

        // truncated row from offset 2
        for (int i = 0; i < 3; i++) wdat[i] = 8'(8'hC1 + i);
        do_write(16'h0012, 3, "R5 partial row");
        do_read("R5 partial row invalid");

        // full row from offset 5
        for (int i = 0; i < 3; i++) wdat[i] = 8'(8'h5A ^ i);
        do_write(16'h000D, 3, "R2 start offset 5");
        do_read("R2 offsets 5..7");

        // locked page
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'hE0 + i);
        do_write(16'h0020, 8, "R3 locked page");
        do_read("R3 locked page stages array");

        // AND-mode page
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h0F << (i % 5));
        do_write(16'h0048, 8, "R3 AND page");
        do_read("R3 AND page");

        // register row self protection
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h91 + i * 3);
        do_write(16'h0080, 8, "R4 register row");
        do_read("R4 register row");

        // out of range address
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h71 + i);
        do_write(16'h0100, 8, "R11 high address");
        do_read("R11 high address open");

        // copied flag set and cleared
        @(negedge clk) aa_set = 1'b1;
        @(negedge clk) aa_set = 1'b0;
        m_aa = 1'b1;
        do_read("R6 copied flag set");
        wdat[0] = 8'h3C;
        do_write(16'h0014, 1, "R6 write clears copied");
        do_read("R6 copied flag cleared");

        // unknown command is dropped
        pulse_end();
        send(8'h33); send(8'h12); send(8'h34);
        chk({15'd0, in_ready}, 16'd1, "R9 dropped bytes still accepted");
        chk({15'd0, out_valid}, 16'd0, "R9 no output after unknown command");
        do_read("R9 state unchanged");

        // write cut after first address byte
        pulse_end();
        send(8'h0F); send(8'h47);
        pulse_end();
        m_aa = 1'b0; m_pf = 1'b1;
        do_read("R10 address not committed");

        // bus reset in the middle of a read
        pulse_end();
        send(8'hAA);
        begin
            logic [7:0] b;
            recv(b);
            chk({8'h00, b}, {8'h00, m_ta[7:0]}, "R8 first read byte");
        end
        pulse_end();
        @(negedge clk);
        chk({15'd0, out_valid}, 16'd0, "R9 read abandoned");
        chk({15'd0, in_ready}, 16'd1, "R9 command wait after end");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule